// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers the four level-sensitive legacy interrupt pins (INTA to INTD) of several PCI device slots onto four shared interrupt request lines. It then routes each shared line to one input of a 16-line interrupt controller. Each device's pin number is rotated by its slot number before merging. As a result, devices in neighbouring slots that all use INTA spread across different shared lines.

The level on a shared line is the OR of every device pin that maps to it. Four routing registers, one per shared line, pick the controller input that each shared line drives. A value below the line count connects the shared line to that input. Any larger value leaves the shared line unconnected. Each controller input is the OR of all shared lines routed to it. Software reaches the routing registers through a small read/write port. The 16-bit output vector is registered once.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing register reads 0x80 and all bits of `irq_o` are low.
- R2: Device index d sits in slot `SLOT_BASE + d`. Its pin n (0 = INTA … 3 = INTD, request bit `d*4 + n` of `req_i`) feeds shared line `(n + slot - 1) mod 4`.
- R3: A shared line is high while any device pin mapped to it is high. One device dropping its request does not clear the line while another device still holds it.
- R4: `reg_addr` k selects the routing register of shared line k, i.e. configuration offset 0x60 + k. A cycle with `reg_we` high stores `reg_wdata` into that register only. `reg_rdata` always shows the addressed register.
- R5: A routing value v below 16 (0x00 to 0x0F) connects its shared line to `irq_o[v]`. Any value of 16 or more (for example 0x10 or 0x80) leaves that shared line unconnected.
- R6: Each `irq_o` bit is the OR of every shared line whose routing register holds that bit's index. Several shared lines may target the same bit at once.
- R7: A change of `req_i` appears on `irq_o` after exactly one rising clock edge, and not before.
- R8: A routing write appears on `irq_o` one edge after the write edge. The previous target bit is released unless another high shared line is still routed to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_DEV*4 | Device pin request levels, bit d*4+n is device d pin n |
| reg_we | input | 1 | Routing register write strobe |
| reg_addr | input | 2 | Routing register select (shared line index) |
| reg_wdata | input | REG_W | Routing write data |
| reg_rdata | output | REG_W | Addressed routing register contents |
| irq_o | output | NUM_LINES | Registered interrupt-controller line levels |

## Verification
The bench shares one output bit between two shared lines and parks a third shared line on the value 0x10. A design that decoded only the low four bits would then drive bit 0. It holds two devices on one shared line and drops one of them, which catches a design that overwrote the level instead of merging it. It retargets a shared line while its request is high and samples both the cycle right after the write and the one after that. A router that left the old bit stuck, released a bit another line still needs, or came out a cycle early or late would fail there. The values 0x0F and 0x10 probe the boundary between connected and unconnected.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

   localparam int unsigned PINS_PER_DEV = 4;
   localparam int unsigned NUM_PIRQ     = 4;

   // shared line reached by pin 'pin' of a device in slot 'slot'
   function automatic int unsigned pirq_of(input int unsigned slot, input int unsigned pin);
      return (pin + slot + NUM_PIRQ - 1) % NUM_PIRQ;
   endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
   import pirq_router_pkg::*;
#(
   parameter int unsigned NUM_DEV   = 4,
   parameter int unsigned SLOT_BASE = 1,
   localparam int unsigned REQ_W    = NUM_DEV * PINS_PER_DEV
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REQ_W-1:0]    req_i,
   output logic [NUM_PIRQ-1:0] pirq_o
);

   function automatic logic [REQ_W-1:0] pin_mask(input int unsigned p);
      logic [REQ_W-1:0] m;
      m = '0;
      for (int unsigned d = 0; d < NUM_DEV; d++) begin
         for (int unsigned n = 0; n < PINS_PER_DEV; n++) begin
            if (pirq_of(SLOT_BASE + d, n) == p) m[d*PINS_PER_DEV + n] = 1'b1;
         end
      end
      return m;
   endfunction

   for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_pirq
      localparam logic [REQ_W-1:0] MASK = pin_mask(gp);
      assign pirq_o[gp] = |(req_i & MASK);
   end

   for (genvar gd = 0; gd < NUM_DEV; gd++) begin : g_chk_dev
      for (genvar gn = 0; gn < PINS_PER_DEV; gn++) begin : g_chk_pin
         localparam int unsigned TGT = pirq_of(SLOT_BASE + gd, gn);
         AST_PIN_REACHES_PIRQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[gd*PINS_PER_DEV + gn] |-> pirq_o[TGT]); // R3
      end
   end

   AST_PIRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (|pirq_o) |-> (|req_i)); // R2

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
   import pirq_router_pkg::*;
#(
   parameter int unsigned REG_W     = 8,
   parameter logic [REG_W-1:0] RESET_VAL = 8'h80
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic [1:0]                     addr_i,
   input  logic [REG_W-1:0]               wdata_i,
   output logic [REG_W-1:0]               rdata_o,
   output logic [NUM_PIRQ-1:0][REG_W-1:0] route_o
);

   for (genvar gr = 0; gr < NUM_PIRQ; gr++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            route_o[gr] <= RESET_VAL;
         end else if (we_i && (addr_i == 2'(gr))) begin
            route_o[gr] <= wdata_i;
         end
      end

      AST_OTHER_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_i && (addr_i == 2'(gr))) |=> $stable(route_o[gr])); // R4
   end

   assign rdata_o = route_o[addr_i];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (route_o[$past(addr_i)] == $past(wdata_i))); // R4

endmodule

// File: rtl/pirq_line_map.sv
module pirq_line_map
   import pirq_router_pkg::*;
#(
   parameter int unsigned REG_W     = 8,
   parameter int unsigned NUM_LINES = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PIRQ-1:0]            pirq_i,
   input  logic [NUM_PIRQ-1:0][REG_W-1:0] route_i,
   output logic [NUM_LINES-1:0]           line_o
);

   for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
      logic [NUM_PIRQ-1:0] hit;
      for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_src
         // full-width compare: any value at or above NUM_LINES never matches
         assign hit[gp] = (route_i[gp] == REG_W'(gl));
      end
      assign line_o[gl] = |(hit & pirq_i);
   end

   for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_chk
      AST_ROUTED_PIRQ_LIGHTS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (pirq_i[gp] && (route_i[gp] < REG_W'(NUM_LINES))) |->
            line_o[route_i[gp][$clog2(NUM_LINES)-1:0]]); // R6
   end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_router_pkg::*;
#(
   parameter int unsigned NUM_DEV   = 4,
   parameter int unsigned SLOT_BASE = 1,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned NUM_LINES = 16,
   parameter logic [REG_W-1:0] ROUTE_RESET = 8'h80,
   localparam int unsigned REQ_W    = NUM_DEV * PINS_PER_DEV
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REQ_W-1:0]     req_i,
   input  logic                 reg_we,
   input  logic [1:0]           reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [NUM_LINES-1:0] irq_o
);

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("pirq_router: NUM_DEV must be at least 1");
   end
   if (NUM_LINES < 2 || NUM_LINES > (1 << REG_W)) begin : g_bad_lines
      $error("pirq_router: NUM_LINES must fit in a routing register");
   end
   if (ROUTE_RESET < REG_W'(NUM_LINES)) begin : g_bad_reset
      $error("pirq_router: reset routing value must disconnect");
   end

   logic [NUM_PIRQ-1:0]            pirq;
   logic [NUM_PIRQ-1:0][REG_W-1:0] route;
   logic [NUM_LINES-1:0]           line_next;

   pirq_swizzle #(
      .NUM_DEV   (NUM_DEV),
      .SLOT_BASE (SLOT_BASE)
   ) u_swizzle (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .pirq_o (pirq)
   );

   pirq_route_regs #(
      .REG_W     (REG_W),
      .RESET_VAL (ROUTE_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .route_o (route)
   );

   pirq_line_map #(
      .REG_W     (REG_W),
      .NUM_LINES (NUM_LINES)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .pirq_i  (pirq),
      .route_i (route),
      .line_o  (line_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= '0;
      else        irq_o <= line_next;
   end

   AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> $past(|req_i)); // R7

endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] req;
   logic        we;
   logic [1:0]  addr;
   logic [7:0]  wdata;
   logic [7:0]  rdata;
   logic [15:0] irq;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   pirq_router u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .reg_we    (we),
      .reg_addr  (addr),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .irq_o     (irq)
   );

   // {req_i, expected irq_o} with PIRQ0->3, PIRQ1->5, PIRQ2->3, PIRQ3->0x10
   localparam logic [31:0] VEC [14] = '{
      {16'h0000, 16'h0000},
      {16'h0001, 16'h0008},
      {16'h0080, 16'h0008},
      {16'h0010, 16'h0020},
      {16'h0100, 16'h0008},
      {16'h1000, 16'h0000},
      {16'h0008, 16'h0000},
      {16'h0110, 16'h0028},
      {16'h0081, 16'h0008},
      {16'h0080, 16'h0008},
      {16'hFFFF, 16'h0028},
      {16'h0800, 16'h0020},
      {16'h2000, 16'h0008},
      {16'h0000, 16'h0000}
   };

   task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req = '0; we = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq after reset", irq, 16'h0000);
      for (int k = 0; k < 4; k++) begin
         addr = 2'(k);
         #1 check("R1 route reset", 16'(rdata), 16'h0080);
      end
      req = 16'hFFFF;
      step();
      check("R1 unrouted lines stay low", irq, 16'h0000);
      req = '0;
      step();

      // R4: program routing and read back
      wr(2'd0, 8'h03);
      wr(2'd1, 8'h05);
      wr(2'd2, 8'h03);
      wr(2'd3, 8'h10);
      addr = 2'd0; #1 check("R4 readback 0", 16'(rdata), 16'h0003);
      addr = 2'd1; #1 check("R4 readback 1", 16'(rdata), 16'h0005);
      addr = 2'd2; #1 check("R4 readback 2", 16'(rdata), 16'h0003);
      addr = 2'd3; #1 check("R4 readback 3", 16'(rdata), 16'h0010);

      // R2 R3 R5 R6: vector table
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         req = VEC[i][31:16];
         step();
         check($sformatf("R2/R3/R6 vector %0d", i), irq, VEC[i][15:0]);
      end

      // R7: no change before the edge, change after exactly one edge
      @(negedge clk);
      req = 16'h0010;
      #2 check("R7 before edge", irq, 16'h0000);
      step();
      check("R7 after one edge", irq, 16'h0020);

      // R8: retarget PIRQ1 from line 5 to line 7 while held
      wr(2'd1, 8'h07);
      check("R8 old target in write cycle", irq, 16'h0020);
      step();
      check("R8 new target after write", irq, 16'h0080);

      // R8 + R6: shared line 3 kept by PIRQ2 when PIRQ0 moves away
      @(negedge clk);
      req = 16'h0101;
      step();
      check("R6 shared line", irq, 16'h0008);
      wr(2'd0, 8'h09);
      step();
      check("R8 shared line kept", irq, 16'h0208);

      // R5: boundary values 0x0F and 0x10
      @(negedge clk);
      req = 16'h0100;
      wr(2'd2, 8'h0F);
      step();
      check("R5 value 0x0F", irq, 16'h8000);
      wr(2'd2, 8'h10);
      step();
      check("R5 value 0x10 disconnects", irq, 16'h0000);
      wr(2'd2, 8'h00);
      step();
      check("R5 value 0x00", irq, 16'h0001);

      // R4: a write touches only the addressed register
      addr = 2'd3; #1 check("R4 untouched register", 16'(rdata), 16'h0010);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule